// File: doc/BRIEF.md
# Line Latch and Column Polarity Selector

This block sits between the serial column loader of a panel source driver and its analog output stage. Upstream logic assembles a full line of 6-bit gray codes, one per column, on a parallel bus. A line strobe then moves that line into a display latch on its rising edge. While the strobe is high every column output is switched off (high impedance). On the falling edge the latched line is driven out together with the per-column controls the analog stage needs. Those controls are a reference-bank select, a gamma segment index, the position inside the segment, the near and far reference taps, an end-point flag and an output enable.

The bank select alternates between neighbouring columns. A polarity input, sampled at the strobe rising edge, decides which of the two banks the odd-numbered columns take. The even-numbered columns take the other bank, so the two polarities always appear side by side on the panel. The lower bank runs its gray scale in mirror order to the upper bank, and this block computes the tap indices for each bank.

The line bus and the polarity input have no valid/ready handshake and no back-pressure. They are sampled only at the strobe rising edge, and upstream must hold them stable at that clock edge. Everything downstream is a plain registered control per column.

Top module: `ll_line_driver`

## Requirements
- R1: After reset every column enable is 0 and stays 0 until the first strobe falling edge; the driven codes reset to 0.
- R2: At the first clock edge that samples the strobe high, the whole line bus (column k in bits [6k+5:6k]) is captured; later changes of the bus do not reach the outputs of that line.
- R3: Every column enable is 0 from the first clock edge that samples the strobe high until the edge that samples it low again.
- R4: At the clock edge that samples the strobe low after high, the captured codes appear on the column code outputs and all enables become 1 at the same edge.
- R5: Polarity is taken at the strobe rising edge; changes while the strobe is high or afterwards do not affect the banks of that line.
- R6: Bank select 0 means the upper bank (references 0 to 4), 1 means the lower bank (references 5 to 9). With polarity 0, columns with even index (odd column numbers) take bank 0 and odd-index columns take bank 1; polarity 1 swaps them.
- R7: The segment output is code bits [5:4], and the position output is code bits [3:0].
- R8: On the upper bank the near tap is the segment number and the far tap is the segment number plus 1 (code 3F ends on reference 4).
- R9: On the lower bank the scale is mirrored: near tap is 9 minus the segment, far tap is 8 minus the segment (code 00 starts on reference 9, code 3F ends on reference 5).
- R10: The end-point flag of a column is 1 exactly when its code is 3F.
- R11: A strobe held high for exactly two clocks, the shortest allowed width, gives a complete line update.
- R12: Between strobe falling edges with the strobe low, all column outputs hold their values whatever the line bus and polarity inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_strobe | input | 1 | Line strobe: rising edge latches, falling edge drives |
| line_pol | input | 1 | Polarity, sampled at strobe rising edge |
| line_codes | input | NUM_COL*6 | Loaded line, column k in bits [6k+5:6k] |
| col_code | output | NUM_COL*6 | Driven gray code per column |
| col_bank | output | NUM_COL | Bank select per column (0 upper, 1 lower) |
| col_seg | output | NUM_COL*2 | Gamma segment index per column |
| col_pos | output | NUM_COL*4 | Position within the segment per column |
| col_end | output | NUM_COL | Code is the segment end point (3F) |
| col_ref_near | output | NUM_COL*4 | Reference index where the segment starts |
| col_ref_far | output | NUM_COL*4 | Reference index where the segment ends |
| col_en | output | NUM_COL | Output enable per column (0 = high impedance) |

## Verification
The bench builds the block with NUM_COL set to 5. With five columns the line holds a mix of both bank parities and ends on an unpaired column, so the alternation rule is checked at the top column as well. Five codes per line are also enough to place one code in every segment, plus the 00 and 3F end points, in a single line under either polarity. Strobe widths of two, three and four clocks are used, with the bus and polarity disturbed inside and after the high window.

// File: rtl/ll_pkg.sv
package ll_pkg;
  localparam int CODE_W    = 6;
  localparam int SEG_W     = 2;
  localparam int POS_W     = CODE_W - SEG_W;
  localparam int BANK_REFS = (1 << SEG_W) + 1;
  localparam int REF_LAST  = 2 * BANK_REFS - 1;
  localparam int REF_W     = $clog2(REF_LAST + 1);

  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic {
    BANK_UPPER = 1'b0,
    BANK_LOWER = 1'b1
  } bank_e;

  typedef struct packed {
    logic [SEG_W-1:0] seg;
    logic [POS_W-1:0] pos;
    logic             at_end;
    logic [REF_W-1:0] near;
    logic [REF_W-1:0] far;
  } tap_t;

  // Upper bank counts taps upward from reference 0; lower bank mirrors
  // from the last reference downward.
  function automatic tap_t map_code(input code_t c, input bank_e b);
    tap_t t;
    logic [SEG_W-1:0] s;
    s        = c[CODE_W-1 -: SEG_W];
    t.seg    = s;
    t.pos    = c[POS_W-1:0];
    t.at_end = &c;
    if (b == BANK_UPPER) begin
      t.near = REF_W'(s);
      t.far  = REF_W'(s) + REF_W'(1);
    end else begin
      t.near = REF_W'(REF_LAST) - REF_W'(s);
      t.far  = REF_W'(REF_LAST - 1) - REF_W'(s);
    end
    return t;
  endfunction
endpackage

// File: rtl/ll_strobe_edge.sv
module ll_strobe_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  output logic rise,
  output logic fall,
  output logic held,
  output logic drive_on
);
  logic strb_q;
  logic en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      strb_q <= strobe;
      if (strobe) begin
        en_q <= 1'b0;
      end else if (strb_q) begin
        en_q <= 1'b1;
      end
    end
  end

  assign rise     = strobe & ~strb_q;
  assign fall     = ~strobe & strb_q;
  assign held     = strb_q;
  assign drive_on = en_q;

  // R3: outputs stay off while the strobe is seen high
  p_hiz_while_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strb_q |-> !en_q);

  // R4 / R1: enable only ever comes up on a falling edge
  p_en_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q) |-> $past(fall));

  // R11: strobe high for at least two clocks before it falls
  p_min_width_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> $past(strb_q));
endmodule

// File: rtl/ll_line_store.sv
module ll_line_store
  import ll_pkg::*;
#(
  parameter int NUM_COL = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rise,
  input  logic                       fall,
  input  logic                       pol_in,
  input  logic [NUM_COL*CODE_W-1:0]  line_in,
  output code_t [NUM_COL-1:0]        drive_code,
  output logic                       drive_pol
);
  code_t [NUM_COL-1:0] latch_q;
  code_t [NUM_COL-1:0] drive_q;
  logic                pol_q;
  logic                dpol_q;

  for (genvar i = 0; i < NUM_COL; i++) begin : g_col
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        latch_q[i] <= '0;
        drive_q[i] <= '0;
      end else begin
        if (rise) latch_q[i] <= line_in[i*CODE_W +: CODE_W];
        if (fall) drive_q[i] <= latch_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= 1'b0;
      dpol_q <= 1'b0;
    end else begin
      if (rise) pol_q  <= pol_in;
      if (fall) dpol_q <= pol_q;
    end
  end

  assign drive_code = drive_q;
  assign drive_pol  = dpol_q;

  // R2: display latch moves only on a rising edge
  p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(latch_q));

  // R12: driven line moves only on a falling edge
  p_drive_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> ($stable(drive_q) && $stable(dpol_q)));
endmodule

// File: rtl/ll_col_map.sv
module ll_col_map
  import ll_pkg::*;
#(
  parameter int NUM_COL = 12
) (
  input  code_t [NUM_COL-1:0]       drive_code,
  input  logic                      drive_pol,
  output logic [NUM_COL*CODE_W-1:0] code_o,
  output logic [NUM_COL-1:0]        bank_o,
  output logic [NUM_COL*SEG_W-1:0]  seg_o,
  output logic [NUM_COL*POS_W-1:0]  pos_o,
  output logic [NUM_COL-1:0]        end_o,
  output logic [NUM_COL*REF_W-1:0]  near_o,
  output logic [NUM_COL*REF_W-1:0]  far_o
);
  for (genvar i = 0; i < NUM_COL; i++) begin : g_col
    localparam logic ODD_IDX = 1'(i % 2);
    bank_e bank;
    tap_t  tap;

    always_comb begin
      bank = bank_e'(drive_pol ^ ODD_IDX);
      tap  = map_code(drive_code[i], bank);
    end

    assign code_o[i*CODE_W +: CODE_W] = drive_code[i];
    assign bank_o[i]                  = bank;
    assign seg_o[i*SEG_W +: SEG_W]    = tap.seg;
    assign pos_o[i*POS_W +: POS_W]    = tap.pos;
    assign end_o[i]                   = tap.at_end;
    assign near_o[i*REF_W +: REF_W]   = tap.near;
    assign far_o[i*REF_W +: REF_W]    = tap.far;

    // R10 / R8 / R9: the end point lands on the bank's inner reference
    always_comb begin
      if (tap.at_end) begin
        p_end_ref_r10: assert (tap.far == ((bank == BANK_UPPER) ?
                                REF_W'(BANK_REFS - 1) : REF_W'(BANK_REFS)));
      end
    end
  end
endmodule

// File: rtl/ll_line_driver.sv
module ll_line_driver
  import ll_pkg::*;
#(
  parameter int NUM_COL = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      line_strobe,
  input  logic                      line_pol,
  input  logic [NUM_COL*CODE_W-1:0] line_codes,
  output logic [NUM_COL*CODE_W-1:0] col_code,
  output logic [NUM_COL-1:0]        col_bank,
  output logic [NUM_COL*SEG_W-1:0]  col_seg,
  output logic [NUM_COL*POS_W-1:0]  col_pos,
  output logic [NUM_COL-1:0]        col_end,
  output logic [NUM_COL*REF_W-1:0]  col_ref_near,
  output logic [NUM_COL*REF_W-1:0]  col_ref_far,
  output logic [NUM_COL-1:0]        col_en
);
  logic                rise;
  logic                fall;
  logic                held;
  logic                drive_on;
  code_t [NUM_COL-1:0] drive_code;
  logic                drive_pol;

  ll_strobe_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (line_strobe),
    .rise     (rise),
    .fall     (fall),
    .held     (held),
    .drive_on (drive_on)
  );

  ll_line_store #(.NUM_COL(NUM_COL)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise       (rise),
    .fall       (fall),
    .pol_in     (line_pol),
    .line_in    (line_codes),
    .drive_code (drive_code),
    .drive_pol  (drive_pol)
  );

  ll_col_map #(.NUM_COL(NUM_COL)) u_map (
    .drive_code (drive_code),
    .drive_pol  (drive_pol),
    .code_o     (col_code),
    .bank_o     (col_bank),
    .seg_o      (col_seg),
    .pos_o      (col_pos),
    .end_o      (col_end),
    .near_o     (col_ref_near),
    .far_o      (col_ref_far)
  );

  assign col_en = {NUM_COL{drive_on}};

  // R3: strobe high at the port keeps enables off one edge later
  p_strobe_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    line_strobe |=> (col_en == '0));

  // R4: enables and fresh codes arrive together after the strobe drops
  p_codes_with_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !line_strobe) |=> (col_en == '1));
endmodule

// File: tb/test_ll_line_driver.sv
module test_ll_line_driver;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 5;
  localparam int CW = 6;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             line_strobe = 1'b0;
  logic             line_pol = 1'b0;
  logic [NC*CW-1:0] line_codes = '0;
  logic [NC*CW-1:0] col_code;
  logic [NC-1:0]    col_bank;
  logic [NC*2-1:0]  col_seg;
  logic [NC*4-1:0]  col_pos;
  logic [NC-1:0]    col_end;
  logic [NC*4-1:0]  col_ref_near;
  logic [NC*4-1:0]  col_ref_far;
  logic [NC-1:0]    col_en;

  typedef struct {
    logic [NC*CW-1:0] codes;
    logic             pol;
  } line_t;

  line_t q[$];
  line_t last;
  bit    have_last = 0;
  bit    en_prev = 0;
  int    n_chk = 0;
  int    n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ll_line_driver #(.NUM_COL(NC)) i_ll_line_driver (
    .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe), .line_pol(line_pol),
    .line_codes(line_codes), .col_code(col_code), .col_bank(col_bank),
    .col_seg(col_seg), .col_pos(col_pos), .col_end(col_end),
    .col_ref_near(col_ref_near), .col_ref_far(col_ref_far), .col_en(col_en)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected line when enables come up, then guards holds
  always @(negedge clk) begin
    if (rst_n) begin
      if (col_en[0] && !en_prev) begin
        if (q.size() == 0) begin
          chk("R4 unexpected line", 1, 0);
        end else begin
          last = q.pop_front();
          have_last = 1;
          chk("R4 enables", col_en, (1 << NC) - 1);
          chk("R4 R2 codes", col_code, last.codes);
          for (int i = 0; i < NC; i++) begin
            int c, s, b;
            c = int'(last.codes[i*CW +: CW]);
            s = c >> 4;
            b = int'(last.pol) ^ (i % 2);
            chk("R6 R5 bank", col_bank[i], b);
            chk("R7 segment", col_seg[i*2 +: 2], s);
            chk("R7 position", col_pos[i*4 +: 4], c & 15);
            chk("R10 end flag", col_end[i], (c == 63) ? 1 : 0);
            if (b == 0) begin
              chk("R8 near", col_ref_near[i*4 +: 4], s);
              chk("R8 far", col_ref_far[i*4 +: 4], s + 1);
            end else begin
              chk("R9 near", col_ref_near[i*4 +: 4], 9 - s);
              chk("R9 far", col_ref_far[i*4 +: 4], 8 - s);
            end
          end
        end
      end else if (col_en[0] && have_last) begin
        chk("R12 hold codes", col_code, last.codes);
        chk("R12 hold enables", col_en, (1 << NC) - 1);
      end
      en_prev = col_en[0];
    end
  end

  function automatic logic [NC*CW-1:0] pack(input int a, b, c, d, e);
    logic [NC*CW-1:0] v;
    v = {CW'(e), CW'(d), CW'(c), CW'(b), CW'(a)};
    return v;
  endfunction

  task automatic send_line(input logic [NC*CW-1:0] codes, input logic pol,
                           input int hi, input bit disturb);
    line_t it;
    @(negedge clk);
    line_codes  = codes;
    line_pol    = pol;
    line_strobe = 1'b1;
    it.codes = codes;
    it.pol   = pol;
    q.push_back(it);
    for (int k = 1; k <= hi; k++) begin
      @(negedge clk);
      chk("R3 enables off in strobe window", col_en, 0);
      if (disturb) begin
        line_codes = ~codes;
        line_pol   = ~pol;
      end
    end
    line_strobe = 1'b0;
    // idle with disturbed inputs: outputs must hold (monitor checks R12)
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (disturb) begin
        line_codes = codes ^ {NC*CW{1'b1}};
        line_pol   = ~pol;
      end
    end
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    chk("R1 enables in reset", col_en, 0);
    chk("R1 codes in reset", col_code, 0);
    rst_n = 1'b1;
    line_codes = pack(7, 8, 9, 10, 11);
    repeat (3) @(negedge clk);
    chk("R1 enables before first strobe", col_en, 0);
    chk("R1 codes before first strobe", col_code, 0);

    // R11: minimum strobe width, polarity 0, all segments and both end points
    send_line(pack(8'h00, 8'h0F, 8'h10, 8'h2F, 8'h3F), 1'b0, 2, 1'b0);
    // R2 R5: inputs changed after the rising edge must be ignored
    send_line(pack(8'h3F, 8'h30, 8'h20, 8'h1F, 8'h01), 1'b1, 3, 1'b1);
    send_line(pack(8'h05, 8'h3E, 8'h2A, 8'h15, 8'h3F), 1'b0, 4, 1'b1);
    for (int n = 0; n < 6; n++) begin
      send_line(pack((n * 11) % 64, (n * 23 + 5) % 64, (n * 37 + 9) % 64,
                     (n * 41 + 60) % 64, 63 - n), 1'(n % 2), 2 + (n % 3), 1'(n % 2));
    end

    repeat (3) @(negedge clk);
    chk("R4 all lines delivered", q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule